// File: doc/BRIEF.md
# IO Port with Operator Wait Handshake

This block provides one 8-bit input port and one 8-bit output port on a processor IO bus with active-low request, read and write strobes. Any IO read stalls the processor by pulling its active-low wait line low. The stall lasts until an operator presses a continue button. The qualified signal that ends the stall also clocks a set of switches into an input register. That register is offered to the data bus for the length of the read.

An IO write loads the output register at the start of the write strobe. The output register keeps its value until the next IO write or reset. A lamp output shows when the processor is being held. The port number is not decoded, so every IO address reaches both ports. The button is assumed to be already debounced. All storage is edge-triggered in one clock domain, and the bus strobes are turned into single-cycle enables by edge detection.

Top module: `io_wait_port`

## Requirements
- R1: `wait_n` is low, in the same cycle and with no register, exactly when `iorq_n`, `rd_n` and `cont_btn` are all low. Otherwise it is high, including during IO writes.
- R2: `wait_led` is high exactly when `wait_n` is low.
- R3: The release level is `iorq_n | rd_n | cont_btn`. On a clock edge where this level is high and was low at the previous edge, the input register loads `sw_in`. This happens on a button press during a read, and also when a read ends without a press. The new value is seen after that edge. At every other edge the input register holds its value.
- R4: `rd_oe` is high exactly when `iorq_n` and `rd_n` are both low. `rd_data` equals the input register while `rd_oe` is high and is all zeros while it is low.
- R5: The write strobe level is `iorq_n | wr_n`. On a clock edge where this level is low and was high at the previous edge, `port_out` loads `wr_data`. Later changes of `wr_data` during the same write, and the end of the write, leave `port_out` unchanged.
- R6: While `rst_n` is low, `port_out` and the input register are zero without waiting for a clock edge. After reset, both strobes count as idle (high) at the first edge.
- R7: A low `wr_n` with `iorq_n` high, and IO reads, never change `port_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iorq_n | input | 1 | IO request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cont_btn | input | 1 | Operator continue button, high when pressed |
| sw_in | input | 8 | Switch value for the input port |
| wr_data | input | 8 | Data bus value during writes |
| wait_n | output | 1 | Wait request to the processor, active low |
| rd_data | output | 8 | Input register value toward the data bus |
| rd_oe | output | 1 | Data bus drive enable for `rd_data` |
| port_out | output | 8 | Output register |
| wait_led | output | 1 | Lamp showing the processor is held |

## Verification
`wait_n`, `wait_led`, `rd_oe` and `rd_data` are combinational results of the inputs in the same cycle. The bench checks them 1 ns after driving the inputs at a falling clock edge. Both registers change on the rising edge after a qualifying strobe transition. The bench therefore updates its model for that edge and compares `port_out` and the read path at the next falling edge. Reset is checked 1 ns after `rst_n` falls, with no clock edge in between.

// File: rtl/iowp_pkg.sv
package iowp_pkg;
  parameter int unsigned PORT_W = 8;

  typedef struct packed {
    logic rd_qual_n;  // low only during an IO read
    logic rel_lvl;    // rising edge releases the stall and loads switches
    logic wr_strb_n;  // low only during an IO write
  } strobe_t;
endpackage

// File: rtl/iowp_strobe_dec.sv
module iowp_strobe_dec
  import iowp_pkg::*;
(
  input  logic    iorq_n,
  input  logic    rd_n,
  input  logic    wr_n,
  input  logic    cont_btn,
  output strobe_t strb,
  output logic    wait_n,
  output logic    wait_led,
  output logic    rd_oe
);
  always_comb begin
    strb.rd_qual_n = iorq_n | rd_n;
    strb.rel_lvl   = strb.rd_qual_n | cont_btn;
    strb.wr_strb_n = iorq_n | wr_n;
    wait_n         = strb.rel_lvl;
    wait_led       = ~strb.rel_lvl;
    rd_oe          = ~strb.rd_qual_n;
  end
endmodule

// File: rtl/iowp_edge_det.sv
module iowp_edge_det #(
  parameter bit RISING = 1'b1,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fire
);
  logic prev_q, prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= prev_d;
  end

  generate
    if (RISING) begin : g_rise
      assign fire = lvl & ~prev_q;
    end else begin : g_fall
      assign fire = ~lvl & prev_q;
    end
  endgenerate
endmodule

// File: rtl/iowp_latch.sv
module iowp_latch #(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb q_d = en ? d : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else        q_q <= q_d;
  end

  assign q = q_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R3, R7
endmodule

// File: rtl/io_wait_port.sv
module io_wait_port
  import iowp_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         iorq_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         cont_btn,
  input  logic [W-1:0] sw_in,
  input  logic [W-1:0] wr_data,
  output logic         wait_n,
  output logic [W-1:0] rd_data,
  output logic         rd_oe,
  output logic [W-1:0] port_out,
  output logic         wait_led
);
  strobe_t      strb;
  logic         rel_fire;
  logic         wr_fire;
  logic [W-1:0] in_q;

  iowp_strobe_dec u_dec (
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .cont_btn (cont_btn),
    .strb     (strb),
    .wait_n   (wait_n),
    .wait_led (wait_led),
    .rd_oe    (rd_oe)
  );

  iowp_edge_det #(.RISING(1'b1), .IDLE(1'b1)) u_rel_edge (
    .clk (clk), .rst_n (rst_n), .lvl (strb.rel_lvl), .fire (rel_fire)
  );

  iowp_edge_det #(.RISING(1'b0), .IDLE(1'b1)) u_wr_edge (
    .clk (clk), .rst_n (rst_n), .lvl (strb.wr_strb_n), .fire (wr_fire)
  );

  iowp_latch #(.W(W), .RST_VAL('0)) u_in_reg (
    .clk (clk), .rst_n (rst_n), .en (rel_fire), .d (sw_in), .q (in_q)
  );

  iowp_latch #(.W(W), .RST_VAL('0)) u_out_reg (
    .clk (clk), .rst_n (rst_n), .en (wr_fire), .d (wr_data), .q (port_out)
  );

  always_comb rd_data = rd_oe ? in_q : '0;

  AST_STALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !rd_n && !cont_btn) |-> !wait_n); // R1
  AST_BUTTON_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    cont_btn |-> wait_n); // R1
  AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire |=> (in_q == $past(sw_in))); // R3
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0)); // R4
  AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (port_out == $past(wr_data))); // R5
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n || !rd_n) |=> $stable(port_out)); // R7
endmodule

// File: tb/io_wait_port_tb.sv
`timescale 1ns/1ps
module io_wait_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         iorq_n, rd_n, wr_n, cont_btn;
  logic [W-1:0] sw_in, wr_data;
  logic         wait_n, rd_oe, wait_led;
  logic [W-1:0] rd_data, port_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic         m_prev_rel, m_prev_wr;
  logic [W-1:0] m_in, m_out;

  always #2.5 clk = ~clk;

  io_wait_port #(.W(W)) u_dut (
    .clk (clk), .rst_n (rst_n), .iorq_n (iorq_n), .rd_n (rd_n), .wr_n (wr_n),
    .cont_btn (cont_btn), .sw_in (sw_in), .wr_data (wr_data),
    .wait_n (wait_n), .rd_data (rd_data), .rd_oe (rd_oe),
    .port_out (port_out), .wait_led (wait_led)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_wait_n(input logic q, input logic r, input logic b);
    return q | r | b;
  endfunction

  task automatic model_reset();
    m_prev_rel = 1'b1;
    m_prev_wr  = 1'b1;
    m_in       = '0;
    m_out      = '0;
  endtask

  // One cycle: drive at falling edge, check combinational, step model, check after edge
  task automatic step(input logic q, input logic r, input logic w, input logic b,
                      input logic [W-1:0] s, input logic [W-1:0] d);
    logic rel, wrs, ew;
    iorq_n = q; rd_n = r; wr_n = w; cont_btn = b; sw_in = s; wr_data = d;
    #1;
    ew = exp_wait_n(q, r, b);
    chk("R1 wait_n", {7'd0, wait_n}, {7'd0, ew});
    chk("R2 wait_led", {7'd0, wait_led}, {7'd0, ~ew});
    chk("R4 rd_oe", {7'd0, rd_oe}, {7'd0, ~(q | r)});
    chk("R4 rd_data", rd_data, (!q && !r) ? m_in : '0);
    rel = q | r | b;
    wrs = q | w;
    if (!m_prev_rel && rel) m_in = s;
    if (m_prev_wr && !wrs)  m_out = d;
    m_prev_rel = rel;
    m_prev_wr  = wrs;
    @(posedge clk);
    @(negedge clk);
    chk("R5 R7 port_out", port_out, m_out);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] s, d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cont_btn = 1'b0;
    sw_in = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R6 reset port_out", port_out, 8'h00);
    chk("R6 reset rd_data idle", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: input register is zero after reset, seen through a read
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00);
    chk("R6 input reg zero", rd_data, 8'h00);
    // R1/R3: stall held several cycles, then the button releases and loads
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h00);
    chk("R3 captured on press", rd_data, 8'hC3);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h22, 8'h00);

    // R5: capture at write start, later data change ignored
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA7);
    chk("R5 capture at start", port_out, 8'hA7);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h3C);
    chk("R5 hold during write", port_out, 8'hA7);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h99);
    chk("R5 hold after write", port_out, 8'hA7);
    // R7: write strobe without IO request
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h44);
    chk("R7 bare write ignored", port_out, 8'hA7);

    // R3: read ending without a press also loads switches
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 8'h00);
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'h6E, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
    chk("R3 load on read end", rd_data, 8'h6E);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic q, r, w, b;
      q = $urandom_range(0, 1); r = $urandom_range(0, 1);
      w = $urandom_range(0, 1); b = ($urandom_range(0, 3) == 0);
      if (!r && !w) w = 1'b1;
      s = W'($urandom); d = W'($urandom);
      step(q, r, w, b, s, d);
    end

    // R6: asynchronous reset mid-run
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hF1);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    chk("R5 before reset", port_out, 8'hF1);
    #1 rst_n = 1'b0;
    #1;
    chk("R6 async clear", port_out, 8'h00);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 8'h00);
    chk("R6 input reg cleared", rd_data, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule